// File: doc/BRIEF.md
# Flag-Driven Two-Operand Compute Stage

This block is one stage of a dataflow chain. An upstream producer writes operand tokens into a small input register pipe. Each token carries two operands side by side, plus a vector-end marker and an exception bit. A combinational two-input operator, a 32-bit adder by default, turns the token at the head of the input pipe into a result token. The result token is written into a small output register pipe, and a downstream consumer drains it with read strobes.

The stage has a single control signal. A transfer fires when the input pipe is holding data and the output pipe is not full. That one strobe pops the input pipe and pushes the output pipe in the same cycle. The operator holds no control state. A multiplier, or any other two-input combinational unit, can be selected by parameter without any change to the control.

Top module: `compute_stage`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `in_full`, `out_valid` and `out_full` are all low.
- R2: `in_full` is high exactly when the input pipe holds DEPTH tokens (default 2). A write while `in_full` is high is ignored, and that token never produces a result.
- R3: A transfer happens on a clock edge only if, before that edge, the input pipe holds at least one token and `out_full` is low. A token written at edge k can be transferred at edge k+1 at the earliest.
- R4: A transfer removes the head token from the input pipe and adds its result to the output pipe on the same edge.
- R5: `out_data` is (A + B) mod 2^32. The input token is packed as `in_a` (operand A, bits 31:0) and `in_b` (operand B, bits 63:32).
- R6: `out_exc` is the OR of the token's `in_exc` bit and the adder's unsigned carry out of bit 31.
- R7: `out_last` equals the `in_last` bit of the token that produced the result.
- R8: While `out_full` is high and `out_rd` is low, no transfer happens. The head result stays unchanged on `out_data` until `out_rd` is pulsed.
- R9: When every result has been read and no token is waiting, both `out_valid` and `out_full` are low.
- R10: Results leave in the order their tokens were written. A read while `out_valid` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr | input | 1 | Write strobe for an operand token |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_last | input | 1 | Vector-end marker of the token |
| in_exc | input | 1 | Exception bit carried by the token |
| in_full | output | 1 | Input pipe is full |
| out_rd | input | 1 | Read strobe; drops the head result |
| out_data | output | 32 | Head result value |
| out_last | output | 1 | Vector-end marker of the head result |
| out_exc | output | 1 | Exception bit of the head result |
| out_valid | output | 1 | Output pipe holds at least one result |
| out_full | output | 1 | Output pipe is full |

## Verification
The assertions assume the producer and consumer may assert their strobes at any time, even against a full or empty pipe. The bench deliberately writes into a full input pipe and reads from an empty output pipe. They also assume `rst` is high from time zero and that inputs change only between clock edges. The stimulus drives every input on the falling edge and holds reset across the first edges. Random phases mix strobes and operand values that include carry-producing sums, so the stall, carry and ordering paths are all reached.

// File: rtl/stage_pkg.sv
package stage_pkg;
  typedef enum logic [0:0] {
    OPK_ADD = 1'b0,
    OPK_MUL = 1'b1
  } op_kind_e;
endpackage

// File: rtl/flag_pipe.sv
module flag_pipe #(
  parameter int W     = 34,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [W-1:0]                 wdata,
  output logic                         full,
  input  logic                         rd,
  output logic [W-1:0]                 rdata,
  output logic                         has_data,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n;
  logic          full_q, has_q;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr & ~full_q;
  assign rd_ok = rd & has_q;
  assign cnt_n = cnt + CW'(wr_ok) - CW'(rd_ok);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      full_q <= 1'b0;
      has_q  <= 1'b0;
    end else begin
      if (wr_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt    <= cnt_n;
      full_q <= (cnt_n == CW'(DEPTH));
      has_q  <= (cnt_n != '0);
    end
  end

  assign rdata    = mem[rp];
  assign full     = full_q;
  assign has_data = has_q;
  assign level    = cnt;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wr && !rd) |=> (level == CW'(DEPTH))); // R2
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (has_data && !rd) |=> $stable(rdata)); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (!has_data && rd && !wr) |=> (level == '0)); // R10
endmodule

// File: rtl/two_in_op.sv
module two_in_op
  import stage_pkg::*;
#(
  parameter int       W    = 32,
  parameter op_kind_e KIND = OPK_ADD
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         exc
);
  generate
    if (KIND == OPK_ADD) begin : g_add
      logic [W:0] wide;
      assign wide = {1'b0, a} + {1'b0, b};
      assign y    = wide[W-1:0];
      assign exc  = wide[W];
    end else begin : g_mul
      logic [2*W-1:0] prod;
      assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      assign y    = prod[W-1:0];
      assign exc  = |prod[2*W-1:W];
    end
  endgenerate
endmodule

// File: rtl/compute_stage.sv
module compute_stage
  import stage_pkg::*;
#(
  parameter int       W     = 32,
  parameter int       DEPTH = 2,
  parameter op_kind_e KIND  = OPK_ADD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_wr,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_last,
  input  logic         in_exc,
  output logic         in_full,
  input  logic         out_rd,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         out_exc,
  output logic         out_valid,
  output logic         out_full
);
  localparam int IW = 2 * W + 2;
  localparam int OW = W + 2;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] in_tok, head_tok;
  logic [OW-1:0] res_tok, out_tok;
  logic          src_has, dst_full, fire;
  logic [CW-1:0] src_lvl, dst_lvl;
  logic [W-1:0]  op_y;
  logic          op_exc;

  assign in_tok = {in_last, in_exc, in_b, in_a};

  flag_pipe #(.W(IW), .DEPTH(DEPTH)) u_src (
    .clk(clk), .rst(rst), .wr(in_wr), .wdata(in_tok), .full(in_full),
    .rd(fire), .rdata(head_tok), .has_data(src_has), .level(src_lvl)
  );

  two_in_op #(.W(W), .KIND(KIND)) u_op (
    .a(head_tok[W-1:0]), .b(head_tok[2*W-1:W]), .y(op_y), .exc(op_exc)
  );

  assign fire    = src_has & ~dst_full;
  assign res_tok = {head_tok[IW-1], head_tok[IW-2] | op_exc, op_y};

  flag_pipe #(.W(OW), .DEPTH(DEPTH)) u_dst (
    .clk(clk), .rst(rst), .wr(fire), .wdata(res_tok), .full(dst_full),
    .rd(out_rd), .rdata(out_tok), .has_data(out_valid), .level(dst_lvl)
  );

  assign out_full = dst_full;
  assign out_data = out_tok[W-1:0];
  assign out_exc  = out_tok[W];
  assign out_last = out_tok[W+1];

  AST_STALL_OUT: assert property (@(posedge clk) disable iff (rst)
    (out_full && !out_rd) |=> $stable(dst_lvl)); // R8
  AST_STALL_IN: assert property (@(posedge clk) disable iff (rst)
    (out_full && !out_rd && !in_wr) |=> $stable(src_lvl)); // R8
  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (!src_has && !out_rd) |=> $stable(dst_lvl)); // R3
endmodule

// File: tb/tb_compute_stage.sv
module tb_compute_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_wr = 1'b0, in_last = 1'b0, in_exc = 1'b0, out_rd = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_full, out_last, out_exc, out_valid, out_full;
  logic [31:0] out_data;

  int total = 0;
  int bad   = 0;

  logic [65:0] src_q[$];
  logic [33:0] dst_q[$];

  always #10 clk = ~clk;

  compute_stage dut (
    .clk(clk), .rst(rst), .in_wr(in_wr), .in_a(in_a), .in_b(in_b),
    .in_last(in_last), .in_exc(in_exc), .in_full(in_full), .out_rd(out_rd),
    .out_data(out_data), .out_last(out_last), .out_exc(out_exc),
    .out_valid(out_valid), .out_full(out_full)
  );

  function automatic logic [33:0] model_op(logic [65:0] t);
    logic [32:0] s;
    s = {1'b0, t[31:0]} + {1'b0, t[63:32]};
    return {t[65], t[64] | s[32], s[31:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      src_q.delete();
      dst_q.delete();
    end else begin
      bit wr_ok, go, rd_ok;
      wr_ok = in_wr && (src_q.size() < 2);
      go    = (src_q.size() > 0) && (dst_q.size() < 2);
      rd_ok = out_rd && (dst_q.size() > 0);
      if (rd_ok) void'(dst_q.pop_front());
      if (go) dst_q.push_back(model_op(src_q.pop_front()));
      if (wr_ok) src_q.push_back({in_last, in_exc, in_b, in_a});
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(in_full == (src_q.size() == 2), "R2 in_full", 64'(in_full), 64'(src_q.size() == 2));
    chk(out_valid == (dst_q.size() > 0), "R3 R4 out_valid", 64'(out_valid), 64'(dst_q.size() > 0));
    chk(out_full == (dst_q.size() == 2), "R8 out_full", 64'(out_full), 64'(dst_q.size() == 2));
    if (dst_q.size() > 0) begin
      chk(out_data == dst_q[0][31:0], "R5 R10 out_data", 64'(out_data), 64'(dst_q[0][31:0]));
      chk(out_exc == dst_q[0][32], "R6 out_exc", 64'(out_exc), 64'(dst_q[0][32]));
      chk(out_last == dst_q[0][33], "R7 out_last", 64'(out_last), 64'(dst_q[0][33]));
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic put(bit w, logic [31:0] a, logic [31:0] b, bit l, bit e, bit r);
    in_wr = w; in_a = a; in_b = b; in_last = l; in_exc = e; out_rd = r;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(!in_full && !out_valid && !out_full, "R1 reset flags",
        64'({in_full, out_valid, out_full}), 64'(0));
    rst = 1'b0;
    step();
    chk(!in_full && !out_valid && !out_full, "R1 after reset",
        64'({in_full, out_valid, out_full}), 64'(0));
    // burst of five tokens with no reads: fills both pipes, last write ignored (R2)
    put(1, 32'hFFFF_FFFF, 32'h1, 0, 0, 0); step();
    put(1, 32'd5, 32'd7, 1, 0, 0); step();
    put(1, 32'h8000_0000, 32'h8000_0000, 0, 0, 0); step();
    put(1, 32'd10, 32'd20, 1, 1, 0); step();
    put(1, 32'd99, 32'd1, 0, 0, 0); step();
    // stall with both pipes full (R8)
    put(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step();
    chk(in_full && out_full, "R8 stall both full", 64'({in_full, out_full}), 64'(3));
    chk(out_data == 32'h0, "R5 wrapped sum", 64'(out_data), 64'(0));
    chk(out_exc == 1'b1, "R6 carry exception", 64'(out_exc), 64'(1));
    // drain including reads of an empty pipe (R10)
    put(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) step();
    chk(!out_valid && !out_full && !in_full, "R9 drained",
        64'({in_full, out_valid, out_full}), 64'(0));
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [3:0]  sel;
      ra  = $urandom;
      rb  = $urandom;
      sel = 4'($urandom);
      put(sel[0] | sel[1], ra, rb, sel[2], sel[3] & sel[0], sel[1] ^ sel[2]);
      step();
    end
    put(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) step();
    chk(!out_valid && !out_full, "R9 final drain", 64'({out_valid, out_full}), 64'(0));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule